// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock Core with Alarm

This core holds the wall time as an unsigned count of seconds. It advances that count once per pulse on a one-second strobe, which comes from an external calibrated divider. Software reaches the core through a small 32-bit register bus. There it can stage a new time, program an alarm instant, watch two event flags and gate them onto two interrupt lines. A control word with two plain bits drives the battery-switch and oscillator-enable pins. A calibration word is held for the divider, with a one-cycle pulse to tell the divider to restart.

A staged time does not replace the running count at once. It is copied in on the next strobe, and until then software can read it back from its own offset. Events are acknowledged by writing ones to the flag register. Gating is changed through a pair of set-only and clear-only registers, so no read-modify-write is needed.

Top module: `rtcs_core`

## Requirements
- R1: After reset these registers read 0: current time (0x10), staged time (0x04), alarm (0x18), flags (0x20), gate (0x24) and control (0x40). Calibration (0x0C) reads 0x198233 and both interrupt outputs are low.
- R2: A strobe with no staged time pending adds one to the current time. Every strobe sets flag bit 0, the seconds event.
- R3: A write to offset 0x00 stages a time that reads back at 0x04 and leaves the current time unchanged. The next strobe makes the current time equal to the staged value rather than adding one, and later strobes count up from it.
- R4: Writing to the flags (0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event arrives in the same cycle as its clear, the event wins.
- R5: Writing 1s to 0x28 sets the matching gate bits and writing 1s to 0x2C clears them. Zero bits have no effect, and the gate reads at 0x24.
- R6: Flag bit 1, the alarm event, sets on a strobe whose resulting current time equals the alarm register (0x18). Writing an alarm value equal to the present time sets no flag by itself.
- R7: The seconds interrupt output is high exactly while flag bit 0 and gate bit 0 are both 1. The alarm output follows bit 1 in the same way.
- R8: The control register (0x40) stores bit 31 (battery switch) and bit 24 (oscillator enable), reads every other bit as 0 and drives the two matching output pins.
- R9: A write to 0x08 stores the low 21 bits as calibration, which reads back at 0x0C and drives the calibration output. The calibration pulse output is high for the single cycle after the write.
- R10: Offset 0x14 returns the divider's tick count zero-extended. Write-only offsets (0x00, 0x08, 0x28, 0x2C) and unmapped offsets read 0.
- R11: The current time wraps from 0xFFFFFFFF to 0 on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| tick_cnt_i | input | 16 | Sub-second count from the divider |
| bus_sel_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| irq_sec_o | output | 1 | Seconds interrupt |
| irq_alarm_o | output | 1 | Alarm interrupt |
| calib_o | output | 21 | Calibration word for the divider |
| calib_wr_o | output | 1 | One-cycle pulse after a calibration write |
| batt_en_o | output | 1 | Battery switch enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The counter is driven with plain strobes from reset, with a staged load taken on the next strobe, and with a load at the all-ones value. These cases separate a load path from an increment path, and they show the wrap. The alarm is approached one strobe at a time. This shows that it fires on the matching strobe and not on an earlier one, and that writing an alarm equal to the present time does not fire it. Flag and gate writes use mixed one and zero patterns, plus a clear that coincides with a strobe. This separates set priority from clear priority and shows that a zero bit in a write changes nothing.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;

    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int N_IRQ   = 2;
    localparam int IRQ_SEC = 0;
    localparam int IRQ_ALM = 1;

    localparam int CTRL_BATT_BIT = 31;
    localparam int CTRL_OSC_BIT  = 24;

    // register offsets decoded by software
    localparam logic [ADDR_W-1:0] OFS_STAGE_WR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAGE_RD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAL_WR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CAL_RD   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_NOW      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TICK     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ALARM    = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FLAGS    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_GATE     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_GATE_SET = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_GATE_CLR = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h40;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
    } bus_req_t;

    typedef struct packed {
        logic batt_en;
        logic osc_en;
    } ctrl_t;

    function automatic logic wr_hit(bus_req_t r, logic [ADDR_W-1:0] ofs);
        return r.sel && r.we && (r.addr == ofs);
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_to_word(ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTRL_BATT_BIT] = c.batt_en;
        w[CTRL_OSC_BIT]  = c.osc_en;
        return w;
    endfunction

endpackage

// File: rtl/rtcs_timekeeper.sv
module rtcs_timekeeper #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              stage_wr,
    input  logic [TIME_W-1:0] stage_val,
    output logic [TIME_W-1:0] now_q,
    output logic [TIME_W-1:0] staged_q,
    output logic              pend_q,
    output logic [TIME_W-1:0] next_now
);

    always_comb begin
        next_now = pend_q ? staged_q : now_q + TIME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q    <= '0;
            staged_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (sec_tick) begin
                now_q <= next_now;
            end
            if (stage_wr) begin
                staged_q <= stage_val;
                pend_q   <= 1'b1;
            end else if (sec_tick) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtcs_irq_ctrl.sv
module rtcs_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         flag_wr,
    input  logic         gate_set_wr,
    input  logic         gate_clr_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] gate_q,
    output logic [N-1:0] irq
);

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
                gate_q[i] <= 1'b0;
            end else begin
                if (set_ev[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (flag_wr && wbits[i]) begin
                    flag_q[i] <= 1'b0;
                end
                if (gate_set_wr && wbits[i]) begin
                    gate_q[i] <= 1'b1;
                end else if (gate_clr_wr && wbits[i]) begin
                    gate_q[i] <= 1'b0;
                end
            end
        end
        assign irq[i] = flag_q[i] & gate_q[i];
    end

endmodule

// File: rtl/rtcs_cfg_regs.sv
module rtcs_cfg_regs
    import rtcs_pkg::*;
#(
    parameter int                 TIME_W    = 32,
    parameter int                 CALIB_W   = 21,
    parameter logic [CALIB_W-1:0] CALIB_RST = 21'h198233
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_wr,
    input  logic              cal_wr,
    input  logic              ctrl_wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [TIME_W-1:0] alarm_q,
    output logic [CALIB_W-1:0] cal_q,
    output logic              cal_pulse_q,
    output ctrl_t             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q     <= '0;
            cal_q       <= CALIB_RST;
            cal_pulse_q <= 1'b0;
            ctrl_q      <= '0;
        end else begin
            cal_pulse_q <= cal_wr;
            if (alarm_wr) begin
                alarm_q <= wdata[TIME_W-1:0];
            end
            if (cal_wr) begin
                cal_q <= wdata[CALIB_W-1:0];
            end
            if (ctrl_wr) begin
                ctrl_q.batt_en <= wdata[CTRL_BATT_BIT];
                ctrl_q.osc_en  <= wdata[CTRL_OSC_BIT];
            end
        end
    end

endmodule

// File: rtl/rtcs_core.sv
module rtcs_core
    import rtcs_pkg::*;
#(
    parameter int                 TIME_W    = 32,
    parameter int                 TICK_W    = 16,
    parameter int                 CALIB_W   = 21,
    parameter logic [CALIB_W-1:0] CALIB_RST = 21'h198233
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_tick_i,
    input  logic [TICK_W-1:0]  tick_cnt_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [7:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_sec_o,
    output logic               irq_alarm_o,
    output logic [CALIB_W-1:0] calib_o,
    output logic               calib_wr_o,
    output logic               batt_en_o,
    output logic               osc_en_o
);

    bus_req_t req;
    assign req = '{sel: bus_sel_i, we: bus_we_i, addr: bus_addr_i, wdata: bus_wdata_i};

    logic stage_wr;
    logic alarm_wr;
    logic cal_wr;
    logic ctrl_wr;
    logic flag_wr;
    logic gate_set_wr;
    logic gate_clr_wr;

    assign stage_wr    = wr_hit(req, OFS_STAGE_WR);
    assign alarm_wr    = wr_hit(req, OFS_ALARM);
    assign cal_wr      = wr_hit(req, OFS_CAL_WR);
    assign ctrl_wr     = wr_hit(req, OFS_CTRL);
    assign flag_wr     = wr_hit(req, OFS_FLAGS);
    assign gate_set_wr = wr_hit(req, OFS_GATE_SET);
    assign gate_clr_wr = wr_hit(req, OFS_GATE_CLR);

    logic [TIME_W-1:0] now_q;
    logic [TIME_W-1:0] staged_q;
    logic [TIME_W-1:0] next_now;
    logic              pend_q;

    rtcs_timekeeper #(.TIME_W(TIME_W)) u_time (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick_i),
        .stage_wr  (stage_wr),
        .stage_val (req.wdata[TIME_W-1:0]),
        .now_q     (now_q),
        .staged_q  (staged_q),
        .pend_q    (pend_q),
        .next_now  (next_now)
    );

    logic [TIME_W-1:0]  alarm_q;
    logic [CALIB_W-1:0] cal_q;
    logic               cal_pulse_q;
    ctrl_t              ctrl_q;

    rtcs_cfg_regs #(
        .TIME_W    (TIME_W),
        .CALIB_W   (CALIB_W),
        .CALIB_RST (CALIB_RST)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .alarm_wr    (alarm_wr),
        .cal_wr      (cal_wr),
        .ctrl_wr     (ctrl_wr),
        .wdata       (req.wdata),
        .alarm_q     (alarm_q),
        .cal_q       (cal_q),
        .cal_pulse_q (cal_pulse_q),
        .ctrl_q      (ctrl_q)
    );

    logic [N_IRQ-1:0] set_ev;
    logic [N_IRQ-1:0] flag_q;
    logic [N_IRQ-1:0] gate_q;
    logic [N_IRQ-1:0] irq;

    always_comb begin
        set_ev          = '0;
        set_ev[IRQ_SEC] = sec_tick_i;
        set_ev[IRQ_ALM] = sec_tick_i && (next_now == alarm_q);
    end

    rtcs_irq_ctrl #(.N(N_IRQ)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .set_ev      (set_ev),
        .flag_wr     (flag_wr),
        .gate_set_wr (gate_set_wr),
        .gate_clr_wr (gate_clr_wr),
        .wbits       (req.wdata[N_IRQ-1:0]),
        .flag_q      (flag_q),
        .gate_q      (gate_q),
        .irq         (irq)
    );

    always_comb begin
        case (req.addr)
            OFS_STAGE_RD: bus_rdata_o = BUS_W'(staged_q);
            OFS_CAL_RD:   bus_rdata_o = BUS_W'(cal_q);
            OFS_NOW:      bus_rdata_o = BUS_W'(now_q);
            OFS_TICK:     bus_rdata_o = BUS_W'(tick_cnt_i);
            OFS_ALARM:    bus_rdata_o = BUS_W'(alarm_q);
            OFS_FLAGS:    bus_rdata_o = BUS_W'(flag_q);
            OFS_GATE:     bus_rdata_o = BUS_W'(gate_q);
            OFS_CTRL:     bus_rdata_o = ctrl_to_word(ctrl_q);
            default:      bus_rdata_o = '0;
        endcase
    end

    assign irq_sec_o   = irq[IRQ_SEC];
    assign irq_alarm_o = irq[IRQ_ALM];
    assign calib_o     = cal_q;
    assign calib_wr_o  = cal_pulse_q;
    assign batt_en_o   = ctrl_q.batt_en;
    assign osc_en_o    = ctrl_q.osc_en;

endmodule

// File: rtl/rtcs_core_chk.sv
module rtcs_core_chk #(
    parameter int TIME_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              pend,
    input logic [TIME_W-1:0] staged,
    input logic [TIME_W-1:0] now,
    input logic [1:0]        flags,
    input logic [1:0]        gate,
    input logic              irq_sec,
    input logic              irq_alarm
);

    assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !pend) |=> (now == $past(now) + TIME_W'(1)));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(now));

    assert_sec_flag_R2: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> flags[0]);

    assert_load_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && pend) |=> (now == $past(staged)));

    assert_alarm_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(sec_tick));

    assert_sec_line_R7: assert property (@(posedge clk) disable iff (rst)
        irq_sec |-> (flags[0] && gate[0]));

    assert_alarm_line_R7: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> (flags[1] && gate[1]));

endmodule

bind rtcs_core rtcs_core_chk #(.TIME_W(TIME_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick_i),
    .pend      (pend_q),
    .staged    (staged_q),
    .now       (now_q),
    .flags     (flag_q),
    .gate      (gate_q),
    .irq_sec   (irq_sec_o),
    .irq_alarm (irq_alarm_o)
);

// File: tb/test_rtcs_core.sv
`timescale 1ns/1ps
module test_rtcs_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [15:0] tick_cnt = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_sec;
    logic        irq_alarm;
    logic [20:0] calib;
    logic        calib_wr;
    logic        batt_en;
    logic        osc_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtcs_core i_rtcs_core (
        .clk         (clk),
        .rst         (rst),
        .sec_tick_i  (sec_tick),
        .tick_cnt_i  (tick_cnt),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_sec_o   (irq_sec),
        .irq_alarm_o (irq_alarm),
        .calib_o     (calib),
        .calib_wr_o  (calib_wr),
        .batt_en_o   (batt_en),
        .osc_en_o    (osc_en)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d, bit with_tick = 1'b0);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d; sec_tick = with_tick;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        bus_rd(8'h10, v); check("R1", "time", v, 0);
        bus_rd(8'h04, v); check("R1", "staged", v, 0);
        bus_rd(8'h18, v); check("R1", "alarm", v, 0);
        bus_rd(8'h20, v); check("R1", "flags", v, 0);
        bus_rd(8'h24, v); check("R1", "gate", v, 0);
        bus_rd(8'h40, v); check("R1", "ctrl", v, 0);
        bus_rd(8'h0C, v); check("R1", "calib", v, 32'h198233);
        check("R1", "irq lines", {30'd0, irq_alarm, irq_sec}, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        strobe();
        bus_rd(8'h10, v); check("R2", "time after 1 strobe", v, 1);
        bus_rd(8'h20, v); check("R2", "seconds flag", v, 1);
        strobe();
        strobe();
        bus_rd(8'h10, v); check("R2", "time after 3 strobes", v, 3);
    endtask

    task automatic t_load();
        logic [31:0] v;
        do_reset();
        strobe();
        bus_wr(8'h20, 32'h3);
        bus_wr(8'h00, 32'd1000);
        bus_rd(8'h04, v); check("R3", "staged readback", v, 1000);
        bus_rd(8'h10, v); check("R3", "time before strobe", v, 1);
        bus_rd(8'h20, v); check("R3", "no flag before strobe", v, 0);
        strobe();
        bus_rd(8'h10, v); check("R3", "time loaded", v, 1000);
        bus_rd(8'h20, v); check("R3", "flag on loading strobe", v, 1);
        strobe();
        bus_rd(8'h10, v); check("R3", "count after load", v, 1001);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        do_reset();
        strobe();
        bus_wr(8'h20, 32'h0);
        bus_rd(8'h20, v); check("R4", "zero write keeps flag", v, 1);
        bus_wr(8'h20, 32'h2);
        bus_rd(8'h20, v); check("R4", "other bit write keeps flag", v, 1);
        bus_wr(8'h20, 32'h1);
        bus_rd(8'h20, v); check("R4", "one write clears flag", v, 0);
        bus_wr(8'h20, 32'h1, 1'b1);
        bus_rd(8'h20, v); check("R4", "event beats clear", v, 1);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        do_reset();
        strobe();
        check("R7", "sec line gated off", {31'd0, irq_sec}, 0);
        bus_wr(8'h28, 32'h1);
        bus_rd(8'h24, v); check("R5", "gate set", v, 1);
        check("R7", "sec line on", {31'd0, irq_sec}, 1);
        check("R7", "alarm line off", {31'd0, irq_alarm}, 0);
        bus_wr(8'h2C, 32'h0);
        bus_rd(8'h24, v); check("R5", "zero clear no effect", v, 1);
        bus_wr(8'h28, 32'h2);
        bus_rd(8'h24, v); check("R5", "second bit set", v, 3);
        bus_wr(8'h2C, 32'h1);
        bus_rd(8'h24, v); check("R5", "bit 0 cleared", v, 2);
        check("R7", "sec line off after gate clear", {31'd0, irq_sec}, 0);
        bus_wr(8'h28, 32'h1);
        bus_wr(8'h20, 32'h1);
        check("R7", "sec line off after flag clear", {31'd0, irq_sec}, 0);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        do_reset();
        bus_wr(8'h28, 32'h2);
        bus_wr(8'h00, 32'd100);
        strobe();
        bus_wr(8'h18, 32'd100);
        bus_rd(8'h18, v); check("R6", "alarm readback", v, 100);
        bus_rd(8'h20, v); check("R6", "equal write no fire", v & 32'h2, 0);
        bus_wr(8'h18, 32'd102);
        strobe();
        bus_rd(8'h20, v); check("R6", "no fire one early", v & 32'h2, 0);
        check("R7", "alarm line low early", {31'd0, irq_alarm}, 0);
        strobe();
        bus_rd(8'h20, v); check("R6", "fires on match", v & 32'h2, 2);
        check("R7", "alarm line high", {31'd0, irq_alarm}, 1);
        bus_wr(8'h20, 32'h2);
        check("R7", "alarm line low after ack", {31'd0, irq_alarm}, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        do_reset();
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_rd(8'h40, v); check("R8", "ctrl all ones", v, 32'h8100_0000);
        check("R8", "pins", {30'd0, batt_en, osc_en}, 3);
        bus_wr(8'h40, 32'h0100_0000);
        bus_rd(8'h40, v); check("R8", "ctrl osc only", v, 32'h0100_0000);
        check("R8", "pins osc only", {30'd0, batt_en, osc_en}, 1);
    endtask

    task automatic t_calib();
        logic [31:0] v;
        do_reset();
        bus_wr(8'h08, 32'hFFFF_FFFF);
        check("R9", "pulse after write", {31'd0, calib_wr}, 1);
        @(negedge clk);
        check("R9", "pulse one cycle", {31'd0, calib_wr}, 0);
        bus_rd(8'h0C, v); check("R9", "readback", v, 32'h1F_FFFF);
        check("R9", "calib pin", {11'd0, calib}, 32'h1F_FFFF);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        do_reset();
        tick_cnt = 16'hABCD;
        bus_rd(8'h14, v); check("R10", "tick readback", v, 32'h0000_ABCD);
        bus_wr(8'h00, 32'h55);
        bus_rd(8'h00, v); check("R10", "write-only offset", v, 0);
        bus_wr(8'h28, 32'h3);
        bus_rd(8'h28, v); check("R10", "gate-set offset", v, 0);
        bus_rd(8'h3C, v); check("R10", "unmapped offset", v, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        bus_wr(8'h00, 32'hFFFF_FFFF);
        strobe();
        bus_rd(8'h10, v); check("R11", "loaded max", v, 32'hFFFF_FFFF);
        strobe();
        bus_rd(8'h10, v); check("R11", "wrapped", v, 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_load();
        t_flags();
        t_gate();
        t_alarm();
        t_ctrl();
        t_calib();
        t_misc();
        t_wrap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule